// File: doc/BRIEF.md
# Masked Vector Execution Unit

This block executes one element-wise vector operation at a time: add, low half of a multiply, or a copy of either source operand. Two source vectors arrive on flat input buses and the unit writes into a destination vector that it keeps. A per-element mask register decides which destination elements may change. The mask is loaded by two compare operations: not-zero on the first source, or unsigned first-source greater-or-equal second-source. A further operation inverts the whole mask. A two-way select therefore takes four steps: a compare, a masked copy of one source, a complement, and a masked copy of the other source.

The parameter `DENSE` picks one of two issue styles. With `DENSE = 0` the unit walks every element below the active length, one per cycle, and the mask only blocks the write. With `DENSE = 1` it scans the mask and spends one cycle only on each element whose mask bit is set. In that style the run time tracks how many elements are active, not the vector length.

A caller pulses `start` with an opcode and an active length. It keeps both source buses stable while `busy` is high, then waits for the one-cycle `done` pulse.

Top module: `mvx_unit`

## Requirements
- R1: After a synchronous reset every destination element reads 0, every mask bit reads 1, and `busy` and `done` are low.
- R2: Opcodes 0 to 3 write element i as follows: 0 is (a_i + b_i) mod 2^EW, 1 is the low EW bits of a_i * b_i, 2 is a_i, and 3 is b_i. Element i of a flat bus occupies bits [i*EW +: EW]. Elements are written in ascending index order.
- R3: A destination element keeps its value when its mask bit is 0 or its index is at or above the active length. The whole destination is unchanged while the unit is idle.
- R4: With `DENSE = 0`, if `start` is sampled at edge 0 with an arithmetic opcode and active length n, element k is processed at edge k+1. `busy` is high after edges 0 to n-1, and `done` is high only in the cycle after edge n. When n = 0, `done` follows edge 0 and `busy` stays low.
- R5: With `DENSE = 1` the same timing holds with n replaced by the number of set mask bits below the active length. Only those elements take cycles. An all-zero mask gives `done` right after edge 0.
- R6: Opcode 4 sets mask bit i to (a_i != 0), and opcode 5 sets it to (a_i >= b_i) unsigned, for every i below the active length. Other mask bits keep their value. The new mask is visible and `done` is high in the cycle after the start edge.
- R7: Opcode 6 inverts all N mask bits whatever the length, with the same one-cycle completion. This allows a select by masked copies under the mask and then its inverse.
- R8: An active length above N is treated as N.
- R9: A `start` pulse sampled while `busy` is high has no effect. Opcode 7 changes neither the mask nor the destination but still produces `done` after the start edge. The mask does not change while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, sampled only while idle |
| op | input | 3 | Opcode (0 add, 1 multiply-low, 2 copy A, 3 copy B, 4 mask=A!=0, 5 mask=A>=B, 6 invert mask, 7 no operation) |
| vlen | input | $clog2(N+1) | Active element count |
| src_a | input | N*EW | First source vector, element i at [i*EW +: EW] |
| src_b | input | N*EW | Second source vector, same layout |
| dst_q | output | N*EW | Destination vector register |
| mask_q | output | N | Mask register, bit i guards element i |
| busy | output | 1 | Element issue in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The mask and the destination are both visible on the ports. A wrong mask bit therefore shows up at once, in the cycle after the compare or invert. It also shows up later as a destination element that changes when it should not, or stays when it should change. A pending-element set that is too full or too empty changes how long `busy` stays high and where `done` lands. The reference model catches that on the first cycle that differs. In the dense style a wrongly skipped or extra element moves `done` by one cycle for each such element. Each element write is compared in the exact cycle it must land, so a write to the wrong index is seen in the cycle after its edge.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_MOVA  = 3'd2,
    OP_MOVB  = 3'd3,
    OP_CMPNZ = 3'd4,
    OP_CMPGE = 3'd5,
    OP_MNOT  = 3'd6,
    OP_NOP   = 3'd7
  } mvx_op_e;

  function automatic logic is_mask_op(mvx_op_e o);
    return (o == OP_CMPNZ) || (o == OP_CMPGE) || (o == OP_MNOT);
  endfunction
endpackage

// File: rtl/mvx_alu.sv
module mvx_alu
  import mvx_pkg::*;
#(
  parameter int EW = 8
) (
  input  mvx_op_e       op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_MUL:  y = a * b;
      OP_MOVA: y = a;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/mvx_maskgen.sv
module mvx_maskgen
  import mvx_pkg::*;
#(
  parameter int N  = 8,
  parameter int EW = 8
) (
  input  mvx_op_e         op,
  input  logic [N*EW-1:0] src_a,
  input  logic [N*EW-1:0] src_b,
  input  logic [N-1:0]    lim,
  input  logic [N-1:0]    mask_in,
  output logic [N-1:0]    mask_nx
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [EW-1:0] ea, eb;
    logic          hit;
    assign ea  = src_a[i*EW +: EW];
    assign eb  = src_b[i*EW +: EW];
    assign hit = (op == OP_CMPNZ) ? (ea != '0) : (ea >= eb);
    assign mask_nx[i] = (op == OP_MNOT) ? ~mask_in[i]
                      : (lim[i] ? hit : mask_in[i]);
  end
endmodule

// File: rtl/mvx_sched.sv
module mvx_sched #(
  parameter int N     = 8,
  parameter bit DENSE = 1'b0,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [N-1:0]  lim,
  input  logic [N-1:0]  mask,
  output logic          busy,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          seed_empty
);
  logic [N-1:0] pend, seed, first;

  if (DENSE) begin : g_dense
    assign seed = lim & mask;
  end else begin : g_simple
    assign seed = lim;
  end

  assign seed_empty = (seed == '0);
  assign busy       = |pend;
  assign first      = pend & (~pend + N'(1));
  assign last       = ((pend & (pend - N'(1))) == '0);

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (first[i]) idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst)          pend <= '0;
    else if (launch)  pend <= seed;
    else if (busy)    pend <= pend & ~first;
  end

  p_no_launch_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !(launch && busy));
  p_one_per_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($countones(pend) + 1 == $countones($past(pend))));

  if (DENSE) begin : g_chk_dense
    p_issue_active_r5: assert property (@(posedge clk) disable iff (rst)
      busy |-> mask[idx]);
  end else begin : g_chk_simple
    p_in_order_r4: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> (idx == IW'($past(idx) + 1'b1)));
  end
endmodule

// File: rtl/mvx_unit.sv
module mvx_unit
  import mvx_pkg::*;
#(
  parameter int N     = 8,
  parameter int EW    = 8,
  parameter bit DENSE = 1'b0,
  localparam int VW   = $clog2(N + 1),
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [VW-1:0] vlen,
  input  logic [N*EW-1:0] src_a,
  input  logic [N*EW-1:0] src_b,
  output logic [N*EW-1:0] dst_q,
  output logic [N-1:0]  mask_q,
  output logic          busy,
  output logic          done
);
  mvx_op_e       op_in, op_r;
  logic [VW-1:0] vlen_c;
  logic [N-1:0]  lim, mask_nx;
  logic [IW-1:0] idx;
  logic          last, seed_empty, launch, accept;
  logic [EW-1:0] a_arr [N];
  logic [EW-1:0] b_arr [N];
  logic [EW-1:0] dst_mem [N];
  logic [EW-1:0] alu_y;

  assign op_in  = mvx_op_e'(op);
  assign vlen_c = (vlen > VW'(N)) ? VW'(N) : vlen;
  assign accept = start && !busy;
  assign launch = accept && !is_mask_op(op_in) && (op_in != OP_NOP);

  always_comb begin
    for (int i = 0; i < N; i++) lim[i] = (i < int'(vlen_c));
  end

  for (genvar i = 0; i < N; i++) begin : g_el
    assign a_arr[i] = src_a[i*EW +: EW];
    assign b_arr[i] = src_b[i*EW +: EW];
    assign dst_q[i*EW +: EW] = dst_mem[i];
  end

  mvx_maskgen #(.N(N), .EW(EW)) u_maskgen (
    .op(op_in), .src_a(src_a), .src_b(src_b), .lim(lim),
    .mask_in(mask_q), .mask_nx(mask_nx)
  );

  mvx_sched #(.N(N), .DENSE(DENSE)) u_sched (
    .clk(clk), .rst(rst), .launch(launch), .lim(lim), .mask(mask_q),
    .busy(busy), .idx(idx), .last(last), .seed_empty(seed_empty)
  );

  mvx_alu #(.EW(EW)) u_alu (
    .op(op_r), .a(a_arr[idx]), .b(b_arr[idx]), .y(alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      done   <= 1'b0;
      op_r   <= OP_ADD;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (is_mask_op(op_in)) begin
          mask_q <= mask_nx;
          done   <= 1'b1;
        end else if (op_in == OP_NOP) begin
          done <= 1'b1;
        end else begin
          op_r <= op_in;
          if (seed_empty) done <= 1'b1;
        end
      end
      if (busy && last) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) dst_mem[i] <= '0;
    end else if (busy && mask_q[idx]) begin
      dst_mem[idx] <= alu_y;
    end
  end

  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(dst_q));
  p_gated_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !mask_q[idx]) |=> $stable(dst_q));
  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mask_q));
endmodule

// File: tb/mvx_unit_bench.sv
module mvx_unit_bench;
  localparam int N  = 8;
  localparam int EW = 8;
  localparam int VW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [VW-1:0] vlen = '0;
  logic [N*EW-1:0] sa = '0, sb = '0;
  logic [N*EW-1:0] d0, d1;
  logic [N-1:0] m0, m1;
  logic b0, b1, k0, k1;

  always #2.5 clk = ~clk;

  mvx_unit #(.N(N), .EW(EW), .DENSE(1'b0)) u_mvx_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .vlen(vlen),
    .src_a(sa), .src_b(sb), .dst_q(d0), .mask_q(m0), .busy(b0), .done(k0));
  mvx_unit #(.N(N), .EW(EW), .DENSE(1'b1)) u_mvx_unit_dt (
    .clk(clk), .rst(rst), .start(start), .op(op), .vlen(vlen),
    .src_a(sa), .src_b(sb), .dst_q(d1), .mask_q(m1), .busy(b1), .done(k1));

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  function automatic void check(bit ok, string req, string what,
                                logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  // behavioural reference: per instance, a list of element indices to visit
  int e_dst [2][N];
  bit e_mask [2][N];
  int lst [2][N];
  int hd [2], tl [2];
  bit e_done [2], e_busy [2];
  int e_op [2];

  function automatic int el(logic [N*EW-1:0] v, int i);
    return int'(v[i*EW +: EW]);
  endfunction

  function automatic int calc(int o, int x, int y);
    case (o)
      0: return (x + y) % (1 << EW);
      1: return (x * y) % (1 << EW);
      2: return x;
      default: return y;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (rst) begin
        for (int i = 0; i < N; i++) begin e_dst[m][i] = 0; e_mask[m][i] = 1; end
        hd[m] = 0; tl[m] = 0; e_done[m] = 0; e_busy[m] = 0; e_op[m] = 0;
      end else begin
        e_done[m] = 0;
        if (hd[m] < tl[m]) begin
          int i;
          i = lst[m][hd[m]];
          hd[m]++;
          if (e_mask[m][i]) e_dst[m][i] = calc(e_op[m], el(sa, i), el(sb, i));
          if (hd[m] == tl[m]) e_done[m] = 1;
        end else if (start) begin
          int n;
          n = (int'(vlen) > N) ? N : int'(vlen);
          case (int'(op))
            4: for (int i = 0; i < n; i++) e_mask[m][i] = (el(sa, i) != 0);
            5: for (int i = 0; i < n; i++) e_mask[m][i] = (el(sa, i) >= el(sb, i));
            6: for (int i = 0; i < N; i++) e_mask[m][i] = !e_mask[m][i];
            7: ;
            default: begin
              e_op[m] = int'(op); hd[m] = 0; tl[m] = 0;
              for (int i = 0; i < n; i++)
                if (m == 0 || e_mask[m][i]) begin lst[m][tl[m]] = i; tl[m]++; end
            end
          endcase
          if (int'(op) >= 4 || tl[m] == 0) e_done[m] = 1;
        end
        e_busy[m] = (hd[m] < tl[m]);
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int m = 0; m < 2; m++) begin
        logic [N*EW-1:0] ed, ad;
        logic [N-1:0] em, am;
        for (int i = 0; i < N; i++) begin
          ed[i*EW +: EW] = EW'(e_dst[m][i]);
          em[i] = e_mask[m][i];
        end
        ad = (m == 0) ? d0 : d1;
        am = (m == 0) ? m0 : m1;
        check(ad == ed, cur_req, "dst", 64'(ad), 64'(ed));
        check(am == em, cur_req, "mask", 64'(am), 64'(em));
        check(((m == 0) ? b0 : b1) == e_busy[m], cur_req, "busy",
              64'((m == 0) ? b0 : b1), 64'(e_busy[m]));
        check(((m == 0) ? k0 : k1) == e_done[m], cur_req, "done",
              64'((m == 0) ? k0 : k1), 64'(e_done[m]));
      end
    end
  end

  task automatic run(input int o, input int vl, input int x0, input int x1,
                     input string req);
    int c0 = -1, c1 = -1;
    cur_req = req;
    @(negedge clk);
    op = 3'(o); vlen = VW'(vl); start = 1'b1;
    for (int c = 1; c <= 14; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      if (k0 && c0 < 0) c0 = c;
      if (k1 && c1 < 0) c1 = c;
    end
    check(c0 == x0, req, "simple done cycle", 64'(c0), 64'(x0));
    check(c1 == x1, req, "dense done cycle", 64'(c1), 64'(x1));
  endtask

  function automatic logic [N*EW-1:0] pack(int v [N]);
    logic [N*EW-1:0] r;
    for (int i = 0; i < N; i++) r[i*EW +: EW] = EW'(v[i]);
    return r;
  endfunction

  initial begin
    int va [N] = '{5, 0, 200, 7, 0, 9, 128, 3};
    int vb [N] = '{3, 4, 100, 9, 1, 9, 2, 250};
    int vz [N] = '{0, 0, 0, 0, 0, 0, 0, 0};
    sa = pack(va); sb = pack(vb);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(d0 == '0 && d1 == '0, "R1", "dst after reset", 64'(d0), 64'd0);
    check(m0 == '1 && m1 == '1, "R1", "mask after reset", 64'(m0), 64'hff);
    check(!b0 && !b1 && !k0 && !k1, "R1", "busy/done after reset",
          64'({b0, b1, k0, k1}), 64'd0);

    run(0, 8, 9, 9, "R2");        // add, full mask
    run(1, 5, 6, 6, "R3");        // multiply, tail elements kept
    run(4, 8, 1, 1, "R6");        // mask = a != 0
    run(3, 8, 9, 7, "R5");        // dense skips two masked-off elements
    run(5, 6, 1, 1, "R6");        // mask = a >= b below length 6
    run(2, 6, 7, 4, "R4");        // copy A under mask
    run(6, 8, 1, 1, "R7");        // invert mask
    run(3, 6, 7, 4, "R7");        // copy B under inverted mask
    for (int i = 0; i < 6; i++) begin
      int mx;
      mx = (va[i] >= vb[i]) ? va[i] : vb[i];
      check(el(d0, i) == mx && el(d1, i) == mx, "R7", "select result",
            64'(el(d0, i)), 64'(mx));
    end

    sa = pack(vz);
    run(4, 8, 1, 1, "R6");        // all-zero mask
    run(0, 8, 9, 1, "R5");        // dense with nothing active
    run(6, 8, 1, 1, "R7");        // back to all ones
    sa = pack(va);
    run(0, 12, 9, 9, "R8");       // length above N clamps
    run(1, 0, 1, 1, "R4");        // zero length
    run(7, 8, 1, 1, "R9");        // no-operation

    // R9: a start sampled while busy is ignored
    cur_req = "R9";
    @(negedge clk);
    op = 3'd0; vlen = VW'(8); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    op = 3'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(m0 == '1 && m1 == '1, "R9", "mask after start while busy", 64'(m0), 64'hff);
    repeat (12) @(negedge clk);
    check(m0 == '1 && m1 == '1, "R9", "mask after run", 64'(m0), 64'hff);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule